// File: doc/BRIEF.md
# Event Keep-or-Discard Decision Queue

This block collects one keep-or-discard verdict for every event the acquisition front end captures, and applies those verdicts strictly in the order the events were triggered. Each trigger leading edge opens an undecided entry. A later accept or reject pulse settles the oldest undecided entry, but only if the pulse keeps a minimum distance from that entry's trigger. Verdicts that pass this check wait in a small queue until the event engine says it is ready for the next event.

When a verdict is taken from the queue, a reject asks the event memory manager to release the event's slot. An accept hands the event to the readout controller and waits until the controller reports that it has drained the event. Both sides are plain request/acknowledge handshakes. When either handshake completes, the stored-event count drops by one. A sticky error flag records pulses that came too early and pulses that named both verdicts at once.

Top module: `evq_decision_queue`

## Requirements
- R1: After reset, `stored_cnt_o` is 0 and `err_o`, `free_req_o` and `rdo_req_o` are all low.
- R2: A `trig_i` pulse raises `stored_cnt_o` by one on the next edge when the count is below 7. When the count is already 7, the trigger is ignored and opens no undecided entry.
- R3: An accept or reject pulse that arrives while no undecided trigger exists is ignored. It sets no error and queues no verdict.
- R4: Take the clock edge that samples a trigger and the edge that samples a lone decision pulse aimed at that trigger. If the second edge is 6 or more edges later, the verdict is queued and the trigger counts as decided. If it is fewer than 6 edges later, the pulse is discarded, `err_o` is set, and the trigger stays undecided.
- R5: If `accept_i` and `reject_i` are high in the same cycle, both are dropped and `err_o` is set.
- R6: Queued verdicts are applied in the order of their triggers.
- R7: A reject taken from the queue while `next_ready_i` is high raises `free_req_o` on the next edge. `free_req_o` stays high until an edge samples `free_ack_i` high. On that edge `free_req_o` falls and `stored_cnt_o` drops by one.
- R8: An accept taken from the queue raises `rdo_req_o` on the next edge. `rdo_req_o` stays high until an edge samples `rdo_done_i` high. On that edge `rdo_req_o` falls and `stored_cnt_o` drops by one.
- R9: Once set, `err_o` stays high until reset.
- R10: At most one event is being applied at a time. `free_req_o` and `rdo_req_o` are never high together, and no new verdict is taken while either is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | One-cycle pulse at each trigger leading edge |
| accept_i | input | 1 | Keep verdict pulse |
| reject_i | input | 1 | Discard verdict pulse |
| next_ready_i | input | 1 | Event engine ready to take the next event |
| free_ack_i | input | 1 | Memory manager has released the slot |
| rdo_done_i | input | 1 | Readout controller has drained the event |
| stored_cnt_o | output | 3 | Number of events held in event memory |
| err_o | output | 1 | Sticky protocol error flag |
| free_req_o | output | 1 | Request to release the current event's slot |
| rdo_req_o | output | 1 | Request to read out the current event |

## Verification
Directed runs place decision pulses at 3, 5 and 6 edges after a trigger. These separate the latency boundary from a simple "any pending trigger" check. They also cover pulses with nothing pending, simultaneous accept and reject, and a burst of eight triggers that exposes the full-count limit. An accept, reject, accept sequence distinguishes in-order application from any reordering, because the request that rises shows which verdict was popped. A long constrained-random phase then mixes triggers, verdicts, readiness and slow acknowledges. This compares every output each cycle against a queue-based model, so it catches handshake holding and counter slips under overlapping traffic.

// File: rtl/evq_pkg.sv
// Shared types for the event decision queue.
package evq_pkg;

    // State of the verdict-application engine.
    typedef enum logic [1:0] {
        APPLY_IDLE = 2'd0,
        APPLY_FREE = 2'd1,
        APPLY_READ = 2'd2
    } apply_st_t;

    // Encoding of one queued verdict: 1 keeps the event, 0 discards it.
    localparam logic VERDICT_KEEP    = 1'b1;
    localparam logic VERDICT_DISCARD = 1'b0;

endpackage

// File: rtl/evq_pending_ages.sv
// Ring of undecided triggers, each with a saturating age counter.
// Assumes: the caller never pushes when full (the stored-event limit
// bounds the entries). A slot written at a trigger edge reads 1 and then
// gains one per edge, so on the edge k edges later it reads k (capped).
module evq_pending_ages #(
    parameter int DEPTH   = 7,
    parameter int MIN_LAT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic pop_i,
    output logic empty_o,
    output logic ripe_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AGE_W = $clog2(MIN_LAT + 1);

    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [AGE_W-1:0] slot_age [DEPTH];

    // Write pointer: advance with wrap on every push.
    always_ff @(posedge clk) begin
        if (!rst_n)      wp_q <= '0;
        else if (push_i) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    end

    // Read pointer: advance with wrap on every pop.
    always_ff @(posedge clk) begin
        if (!rst_n)     rp_q <= '0;
        else if (pop_i) rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    end

    // Occupancy: track pushes minus pops.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (push_i && !pop_i) cnt_q <= cnt_q + 1'b1;
        else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [AGE_W-1:0] age_r;
        // Per-slot age: load 1 on write, then count up to the latency cap.
        always_ff @(posedge clk) begin
            if (!rst_n)
                age_r <= '0;
            else if (push_i && wp_q == PTR_W'(g))
                age_r <= AGE_W'(1);
            else if (age_r < AGE_W'(MIN_LAT))
                age_r <= age_r + 1'b1;
        end
        assign slot_age[g] = age_r;
    end

    assign empty_o = (cnt_q == '0);
    assign ripe_o  = !empty_o && (slot_age[rp_q] >= AGE_W'(MIN_LAT));

endmodule

// File: rtl/evq_fifo.sv
// Small first-in first-out store for settled verdicts.
// Assumes: no push when full and no pop when empty (the caller guards both).
module evq_fifo #(
    parameter int DEPTH = 7,
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] dout_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wp_q, rp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    // Storage write at the write pointer.
    always_ff @(posedge clk) begin
        if (push_i) mem_q[wp_q] <= din_i;
    end

    // Write pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      wp_q <= '0;
        else if (push_i) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    end

    // Read pointer with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)     rp_q <= '0;
        else if (pop_i) rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (push_i && !pop_i) cnt_q <= cnt_q + 1'b1;
        else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end

    assign dout_o  = mem_q[rp_q];
    assign empty_o = (cnt_q == '0);

endmodule

// File: rtl/evq_apply_fsm.sv
// Takes one verdict at a time and runs the matching handshake.
// Assumes: next_ready_i means the oldest stored event has finished
// acquisition. The acknowledges only count while their request is high.
module evq_apply_fsm
    import evq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic next_ready_i,
    input  logic q_empty_i,
    input  logic q_head_i,
    output logic q_pop_o,
    input  logic free_ack_i,
    input  logic rdo_done_i,
    output logic free_req_o,
    output logic rdo_req_o,
    output logic retire_o
);
    apply_st_t st_q, st_d;

    // Next-state choice: pop when idle, release when the handshake ends.
    always_comb begin
        st_d     = st_q;
        q_pop_o  = 1'b0;
        retire_o = 1'b0;
        unique case (st_q)
            APPLY_IDLE: begin
                if (next_ready_i && !q_empty_i) begin
                    q_pop_o = 1'b1;
                    st_d    = (q_head_i == VERDICT_KEEP) ? APPLY_READ : APPLY_FREE;
                end
            end
            APPLY_FREE: begin
                if (free_ack_i) begin
                    retire_o = 1'b1;
                    st_d     = APPLY_IDLE;
                end
            end
            APPLY_READ: begin
                if (rdo_done_i) begin
                    retire_o = 1'b1;
                    st_d     = APPLY_IDLE;
                end
            end
            default: st_d = APPLY_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= APPLY_IDLE;
        else        st_q <= st_d;
    end

    assign free_req_o = (st_q == APPLY_FREE);
    assign rdo_req_o  = (st_q == APPLY_READ);

endmodule

// File: rtl/evq_decision_queue.sv
// Top: checks each verdict pulse against the oldest undecided trigger,
// queues the valid ones in trigger order, applies them one by one and
// keeps the stored-event count.
// Assumes: trig_i, accept_i and reject_i are single-cycle pulses in the
// clk domain. A verdict arrives before its event reaches the head of the queue.
module evq_decision_queue #(
    parameter int MAX_EV  = 7,
    parameter int MIN_LAT = 6,
    parameter int CNT_W   = $clog2(MAX_EV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             accept_i,
    input  logic             reject_i,
    input  logic             next_ready_i,
    input  logic             free_ack_i,
    input  logic             rdo_done_i,
    output logic [CNT_W-1:0] stored_cnt_o,
    output logic             err_o,
    output logic             free_req_o,
    output logic             rdo_req_o
);
    logic pend_empty, pend_ripe;
    logic trig_ok, lone, both, take, early;
    logic q_empty, q_head, q_pop, retire;
    logic [CNT_W-1:0] cnt_q;
    logic err_q;

    // Pulse qualification.
    assign trig_ok = trig_i && (cnt_q < CNT_W'(MAX_EV));
    assign both    = accept_i && reject_i;
    assign lone    = accept_i ^ reject_i;
    assign take    = lone && !pend_empty && pend_ripe;
    assign early   = lone && !pend_empty && !pend_ripe;

    evq_pending_ages #(
        .DEPTH   (MAX_EV),
        .MIN_LAT (MIN_LAT)
    ) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (trig_ok),
        .pop_i   (take),
        .empty_o (pend_empty),
        .ripe_o  (pend_ripe)
    );

    evq_fifo #(
        .DEPTH (MAX_EV),
        .WIDTH (1)
    ) u_verdicts (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (take),
        .din_i   (accept_i),
        .pop_i   (q_pop),
        .dout_o  (q_head),
        .empty_o (q_empty)
    );

    evq_apply_fsm u_apply (
        .clk          (clk),
        .rst_n        (rst_n),
        .next_ready_i (next_ready_i),
        .q_empty_i    (q_empty),
        .q_head_i     (q_head),
        .q_pop_o      (q_pop),
        .free_ack_i   (free_ack_i),
        .rdo_done_i   (rdo_done_i),
        .free_req_o   (free_req_o),
        .rdo_req_o    (rdo_req_o),
        .retire_o     (retire)
    );

    // Stored-event count: up on each admitted trigger, down on each retirement.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (trig_ok && !retire) cnt_q <= cnt_q + 1'b1;
        else if (retire && !trig_ok) cnt_q <= cnt_q - 1'b1;
    end

    // Sticky error: early or conflicting verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n)              err_q <= 1'b0;
        else if (both || early)  err_q <= 1'b1;
    end

    assign stored_cnt_o = cnt_q;
    assign err_o        = err_q;

endmodule

// File: rtl/evq_decision_queue_chk.sv
// Protocol checker for the decision queue, bound to the top module.
module evq_decision_queue_chk #(
    parameter int MAX_EV = 7,
    parameter int CNT_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_i,
    input logic             accept_i,
    input logic             reject_i,
    input logic             free_ack_i,
    input logic             rdo_done_i,
    input logic [CNT_W-1:0] stored_cnt_o,
    input logic             err_o,
    input logic             free_req_o,
    input logic             rdo_req_o
);
    logic retiring;
    assign retiring = (free_req_o && free_ack_i) || (rdo_req_o && rdo_done_i);

    // R2: the count never passes the stored-event limit.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stored_cnt_o <= CNT_W'(MAX_EV));

    // R2: a trigger at the limit leaves the count unchanged.
    a_r2_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && stored_cnt_o == CNT_W'(MAX_EV) && !retiring)
        |=> stored_cnt_o == CNT_W'(MAX_EV));

    // R2: a trigger below the limit adds one.
    a_r2_trig_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && stored_cnt_o < CNT_W'(MAX_EV) && !retiring)
        |=> stored_cnt_o == $past(stored_cnt_o) + CNT_W'(1));

    // R5: simultaneous verdicts raise the error.
    a_r5_both_err: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_i && reject_i) |=> err_o);

    // R7: the release request holds until acknowledged, then the count drops.
    a_r7_free_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (free_req_o && !free_ack_i) |=> free_req_o);
    a_r7_free_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (free_req_o && free_ack_i && !trig_i)
        |=> (!free_req_o && stored_cnt_o == $past(stored_cnt_o) - CNT_W'(1)));

    // R8: the readout request holds until drained, then the count drops.
    a_r8_rdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rdo_req_o && !rdo_done_i) |=> rdo_req_o);
    a_r8_rdo_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (rdo_req_o && rdo_done_i && !trig_i)
        |=> (!rdo_req_o && stored_cnt_o == $past(stored_cnt_o) - CNT_W'(1)));

    // R9: the error flag never clears without reset.
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R10: only one handshake runs at a time.
    a_r10_one_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(free_req_o && rdo_req_o));

endmodule

bind evq_decision_queue evq_decision_queue_chk #(
    .MAX_EV (MAX_EV),
    .CNT_W  (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .accept_i     (accept_i),
    .reject_i     (reject_i),
    .free_ack_i   (free_ack_i),
    .rdo_done_i   (rdo_done_i),
    .stored_cnt_o (stored_cnt_o),
    .err_o        (err_o),
    .free_req_o   (free_req_o),
    .rdo_req_o    (rdo_req_o)
);

// File: tb/evq_decision_queue_bench.sv
// Bench: directed corners plus seeded random traffic against a queue model.
module evq_decision_queue_bench;
    localparam int MAX_EV  = 7;
    localparam int MIN_LAT = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_i = 0, accept_i = 0, reject_i = 0;
    logic next_ready_i = 0, free_ack_i = 0, rdo_done_i = 0;
    logic [2:0] stored_cnt_o;
    logic err_o, free_req_o, rdo_req_o;

    always #4 clk = ~clk;

    evq_decision_queue u_evq_decision_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig_i       (trig_i),
        .accept_i     (accept_i),
        .reject_i     (reject_i),
        .next_ready_i (next_ready_i),
        .free_ack_i   (free_ack_i),
        .rdo_done_i   (rdo_done_i),
        .stored_cnt_o (stored_cnt_o),
        .err_o        (err_o),
        .free_req_o   (free_req_o),
        .rdo_req_o    (rdo_req_o)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state.
    int cyc = 0;
    int pend_q[$];
    bit dec_q[$];
    int m_cnt = 0;
    bit m_err = 0;
    int m_st = 0;   // 0 idle, 1 releasing, 2 reading out

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic void model_reset();
        pend_q.delete();
        dec_q.delete();
        m_cnt = 0;
        m_err = 0;
        m_st  = 0;
    endfunction

    // One edge of the requirement-level behaviour, from pre-edge state.
    function automatic void model_edge(bit tr, bit ac, bit rj, bit nr, bit fa, bit rd);
        bit ret = 0;
        bit inc;
        if (m_st == 0 && nr && dec_q.size() > 0) begin
            m_st = dec_q.pop_front() ? 2 : 1;            // R6, R7, R8
        end else if (m_st == 1 && fa) begin
            m_st = 0; ret = 1;
        end else if (m_st == 2 && rd) begin
            m_st = 0; ret = 1;
        end
        if (ac && rj) m_err = 1;                         // R5
        else if ((ac || rj) && pend_q.size() > 0) begin  // R3: nothing pending -> ignored
            if (cyc - pend_q[0] >= MIN_LAT) begin        // R4
                dec_q.push_back(ac);
                void'(pend_q.pop_front());
            end else m_err = 1;
        end
        inc = tr && (m_cnt < MAX_EV);                    // R2
        if (inc) pend_q.push_back(cyc);
        m_cnt = m_cnt + int'(inc) - int'(ret);
    endfunction

    task automatic check_all(string tag);
        chk({tag, " stored_cnt"}, int'(stored_cnt_o), m_cnt);
        chk({tag, " err"},        int'(err_o),        int'(m_err));
        chk({tag, " free_req"},   int'(free_req_o),   int'(m_st == 1));
        chk({tag, " rdo_req"},    int'(rdo_req_o),    int'(m_st == 2));
    endtask

    task automatic step(string tag, bit tr, bit ac, bit rj, bit nr, bit fa, bit rd);
        trig_i = tr; accept_i = ac; reject_i = rj;
        next_ready_i = nr; free_ack_i = fa; rdo_done_i = rd;
        model_edge(tr, ac, rj, nr, fa, rd);
        @(posedge clk);
        cyc++;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        trig_i = 0; accept_i = 0; reject_i = 0;
        next_ready_i = 0; free_ack_i = 0; rdo_done_i = 0;
        repeat (2) @(posedge clk);
        cyc += 2;
        model_reset();
        @(negedge clk);
        rst_n = 1;
        check_all("R1 reset");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R3: stray verdicts with nothing pending.
        step("R3 stray accept", 0, 1, 0, 0, 0, 0);
        step("R3 stray reject", 0, 0, 1, 0, 0, 0);
        // R2 + R7: trigger, reject at 6 edges, release handshake.
        step("R2 trigger", 1, 0, 0, 0, 0, 0);
        idle("R4 wait", 5);
        step("R4 reject at 6", 0, 0, 1, 0, 0, 0);
        step("R7 pop", 0, 0, 0, 1, 0, 0);
        idle("R7 hold", 3);
        step("R7 ack", 0, 0, 0, 0, 1, 0);

        // R4: pulses at 3 and 5 edges are early; 6 is valid. R8 readout.
        step("R4 trigger", 1, 0, 0, 0, 0, 0);
        idle("R4 wait", 2);
        step("R4 accept at 3", 0, 1, 0, 0, 0, 0);
        step("R4 wait", 0, 0, 0, 0, 0, 0);
        step("R4 accept at 5", 0, 1, 0, 0, 0, 0);
        step("R4 accept at 6", 0, 1, 0, 0, 0, 0);
        step("R8 pop", 0, 0, 0, 1, 0, 0);
        step("R8 stray ack", 0, 0, 0, 0, 1, 0);
        idle("R8 hold", 3);
        step("R8 done", 0, 0, 0, 0, 0, 1);
        idle("R9 sticky", 4);
        do_reset();

        // R5: both pulses dropped, later reject decides the trigger.
        step("R5 trigger", 1, 0, 0, 0, 0, 0);
        idle("R5 wait", 6);
        step("R5 both", 0, 1, 1, 0, 0, 0);
        step("R5 reject", 0, 0, 1, 0, 0, 0);
        step("R7 pop", 0, 0, 0, 1, 0, 0);
        step("R7 ack", 0, 0, 0, 0, 1, 0);
        do_reset();

        // R6: keep, discard, keep applied in order; R10 one at a time.
        for (int i = 0; i < 3; i++) step("R6 trigger", 1, 0, 0, 0, 0, 0);
        idle("R6 wait", 6);
        step("R6 accept", 0, 1, 0, 0, 0, 0);
        step("R6 reject", 0, 0, 1, 0, 0, 0);
        step("R6 accept", 0, 1, 0, 0, 0, 0);
        step("R6 pop first", 0, 0, 0, 1, 0, 0);
        step("R10 ready while busy", 0, 0, 0, 1, 0, 0);
        step("R6 done first", 0, 0, 0, 1, 0, 1);
        step("R6 pop second", 0, 0, 0, 1, 0, 0);
        step("R6 ack second", 0, 0, 0, 1, 1, 0);
        step("R6 pop third", 0, 0, 0, 1, 0, 0);
        step("R6 done third", 0, 0, 0, 0, 0, 1);

        // R2: eight triggers, the eighth is ignored at the limit.
        for (int i = 0; i < 8; i++) step("R2 fill", 1, 0, 0, 0, 0, 0);
        idle("R2 wait", 6);
        for (int i = 0; i < 8; i++) step("R2 decide", 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 20; i++) step("R2 drain", 0, 0, 0, 1, 1, 0);
        do_reset();

        // Random phase over all requirements (R2..R10).
        for (int i = 0; i < 4000; i++) begin
            bit tr, ac, rj, nr, fa, rd;
            tr = ($urandom % 100) < 12;
            ac = ($urandom % 100) < 7;
            rj = ($urandom % 100) < 7;
            nr = ($urandom % 100) < 35;
            fa = ($urandom % 100) < 40;
            rd = ($urandom % 100) < 25;
            step("R6 random", tr, ac, rj, nr, fa, rd);
            if (i % 1000 == 999) do_reset();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule